// File: doc/BRIEF.md
# Data-Acquisition Interrupt Controller

This block gathers the event sources of an ADC sequencing subsystem into one active-high interrupt line. Every event is held in a sticky status flag. A flag is set whether or not it is enabled. The matching enable bit only decides whether that flag can raise the interrupt. Software reaches the block through a small register bus with a 4-bit address, separate read and write strobes, and 16-bit data. The bus holds two registers: a read/write enable register and a read-only status register. A strobed read of the status register clears it.

Four events arrive as one-cycle pulses: watchdog limit crossing, pause-instruction decode, short auto-zero done and full calibration done. Three more are derived inside the block:
- An instruction-address trigger compares each fetched sequencer address with a stored 3-bit value. On the first fetch of address 0 after a start, a trigger value of 0 is held back.
- A FIFO-fill trigger compares the conversion count with a stored 5-bit code, where code 0 means 32.
- A wake flag is raised a programmable number of cycles after the subsystem leaves standby.

Top module: `daq_irq_ctrl`

## Requirements
- R1: After reset, the status register, the enable register and `irq` are all 0.
- R2: The enable register sits at address 4'h9. A write stores `bus_wdata & 16'hFFBF`, so bit 6 always reads 0. Writes to the status address 4'h A are ignored. Reads of any address other than 4'h9 and 4'hA return 0. `bus_rdata` is a combinational function of `bus_addr`.
- R3: The status flags are: bit 0 limit, bit 1 address trigger, bit 2 FIFO trigger, bit 3 short auto-zero, bit 4 full calibration, bit 5 pause, bit 7 wake, and bit 6 always 0. A source pulse sampled at a clock edge sets its flag at that edge, whatever the enable register holds.
- R4: A flag stays set until a clock edge that samples `bus_rd` high with `bus_addr` = 4'hA. That edge clears all flags. The read returns the value from before the clear. Looking at `bus_rdata` without `bus_rd` clears nothing.
- R5: If an event and a clearing status read share an edge, the flag of that event is set after the edge.
- R6: `irq` is registered. One edge after the status register and enable bits 0–5 and 7 overlap, `irq` is 1. One edge after they stop overlapping, `irq` is 0.
- R7: An edge that samples `seq_fetch` high with `seq_addr` equal to enable bits [10:8] sets status bit 1. No flag is set without `seq_fetch`.
- R8: The first fetch of address 0 after reset or after a `seq_start` pulse does not set bit 1, even when the trigger value is 0. Every later fetch of address 0 does set it when the trigger value is 0.
- R9: Enable bits [15:11] hold a FIFO code: 1–31 mean that count, and 0 means 32. Status bit 2 is set at an edge where `fifo_count` equals the threshold and did not equal it at the previous edge.
- R10: Call E0 the first edge that samples `standby` low after it was sampled high. Bit 7 is set at edge E0+SETTLE_CYCLES. If `standby` is sampled high again before then, the flag is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears status when addressing 4'hA) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| ev_limit | input | 1 | Watchdog limit crossing pulse |
| ev_pause | input | 1 | Pause-instruction decode pulse |
| ev_short_cal | input | 1 | Short auto-zero complete pulse |
| ev_full_cal | input | 1 | Full calibration complete pulse |
| seq_start | input | 1 | Sequencer start pulse, re-arms address-0 suppression |
| seq_fetch | input | 1 | Sequencer instruction fetch strobe |
| seq_addr | input | 3 | Address of the fetched instruction |
| fifo_count | input | 6 | Conversions currently stored in the FIFO |
| standby | input | 1 | Subsystem is in standby (level) |
| irq | output | 1 | Interrupt request, active high |

## Verification
Every event source sets its flag at the same edge that samples it, so the bench checks the flag right after that edge. It reads the flag through a non-strobed look at `bus_rdata`, and because that look has no strobe it does not disturb the flag. `irq` follows the status register one edge later, so the bench checks it a full cycle after the flag. When a clearing read is issued, the bench checks `irq` one cycle later still. The wake flag is due exactly SETTLE_CYCLES edges after the first edge that samples `standby` low. The bench walks one cycle at a time and checks that the flag is still low on every cycle before that edge and is high on that edge.

// File: rtl/daq_irq_pkg.sv
package daq_irq_pkg;
  localparam int DW     = 16;
  localparam int BUS_AW = 4;
  localparam int NFLAG  = 8;

  localparam logic [BUS_AW-1:0] ADDR_ENABLE = 4'h9;
  localparam logic [BUS_AW-1:0] ADDR_STATUS = 4'hA;

  localparam int F_LIMIT    = 0;
  localparam int F_ADDR     = 1;
  localparam int F_FIFO     = 2;
  localparam int F_SHORTCAL = 3;
  localparam int F_FULLCAL  = 4;
  localparam int F_PAUSE    = 5;
  localparam int F_SPARE    = 6;
  localparam int F_WAKE     = 7;

  // flags that exist; the spare position never sets or gates
  localparam logic [NFLAG-1:0] FLAG_MASK = 8'hBF;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import daq_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic [NFLAG-1:0]  status_q,
  output logic [DW-1:0]     enable_q,
  output logic [DW-1:0]     bus_rdata
);
  localparam logic [DW-1:0] EN_KEEP = {{(DW-NFLAG){1'b1}}, FLAG_MASK};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      enable_q <= '0;
    else if (bus_wr && bus_addr == ADDR_ENABLE)
      enable_q <= bus_wdata & EN_KEEP;
  end

  always_comb begin
    case (bus_addr)
      ADDR_ENABLE: bus_rdata = enable_q;
      ADDR_STATUS: bus_rdata = {{(DW-NFLAG){1'b0}}, status_q};
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_seq_match.sv
module irq_seq_match #(
  parameter int SEQ_AW  = 3,
  parameter int FIFO_TW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_start,
  input  logic             seq_fetch,
  input  logic [SEQ_AW-1:0] seq_addr,
  input  logic [SEQ_AW-1:0] trig_addr,
  input  logic [FIFO_TW:0]  fifo_count,
  input  logic [FIFO_TW-1:0] fifo_code,
  output logic             addr_hit,
  output logic             fifo_hit
);
  localparam logic [FIFO_TW:0] FIFO_FULL = (FIFO_TW+1)'(1) << FIFO_TW;

  logic armed_q;
  logic first_zero;
  logic [FIFO_TW:0] fifo_thr;
  logic fifo_eq;
  logic fifo_eq_q;

  // suppression of the very first fetch of address 0 after start or reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      armed_q <= 1'b1;
    else if (seq_start)
      armed_q <= 1'b1;
    else if (seq_fetch && seq_addr == '0)
      armed_q <= 1'b0;
  end

  assign first_zero = armed_q && (seq_addr == '0);
  assign addr_hit   = seq_fetch && (seq_addr == trig_addr) && !first_zero;

  // threshold code zero stands for a full FIFO
  assign fifo_thr = (fifo_code == '0) ? FIFO_FULL : {1'b0, fifo_code};
  assign fifo_eq  = (fifo_count == fifo_thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fifo_eq_q <= 1'b0;
    else
      fifo_eq_q <= fifo_eq;
  end

  assign fifo_hit = fifo_eq && !fifo_eq_q;
endmodule

// File: rtl/irq_settle_timer.sv
module irq_settle_timer #(
  parameter int SETTLE_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic standby,
  output logic wake_hit
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic          sb_q;
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          exit_seen;

  assign exit_seen = sb_q && !standby;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb_q   <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sb_q <= standby;
      if (standby) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (exit_seen) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == LAST)
          busy_q <= 1'b0;
        else
          cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign wake_hit = busy_q && !standby && (cnt_q == LAST);
endmodule

// File: rtl/irq_status.sv
module irq_status
  import daq_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] ev_vec,
  input  logic             clr,
  input  logic [NFLAG-1:0] en_mask,
  output logic [NFLAG-1:0] status_q,
  output logic             irq
);
  logic [NFLAG-1:0] kept;

  // new events win over a clearing read in the same cycle
  assign kept = clr ? '0 : status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      irq      <= 1'b0;
    end else begin
      status_q <= kept | (ev_vec & FLAG_MASK);
      irq      <= |(status_q & en_mask & FLAG_MASK);
    end
  end
endmodule

// File: rtl/daq_irq_ctrl.sv
module daq_irq_ctrl
  import daq_irq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 500000,
  parameter int SEQ_AW        = 3,
  parameter int FIFO_TW       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              ev_limit,
  input  logic              ev_pause,
  input  logic              ev_short_cal,
  input  logic              ev_full_cal,
  input  logic              seq_start,
  input  logic              seq_fetch,
  input  logic [SEQ_AW-1:0] seq_addr,
  input  logic [FIFO_TW:0]  fifo_count,
  input  logic              standby,
  output logic              irq
);
  localparam int TRIG_LSB = NFLAG;
  localparam int FIFO_LSB = TRIG_LSB + SEQ_AW;

  logic [DW-1:0]    enable_q;
  logic [NFLAG-1:0] status_q;
  logic [NFLAG-1:0] ev_vec;
  logic             addr_hit;
  logic             fifo_hit;
  logic             wake_hit;
  logic             stat_read;

  assign stat_read = bus_rd && (bus_addr == ADDR_STATUS);

  irq_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .status_q  (status_q),
    .enable_q  (enable_q),
    .bus_rdata (bus_rdata)
  );

  irq_seq_match #(
    .SEQ_AW  (SEQ_AW),
    .FIFO_TW (FIFO_TW)
  ) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .seq_start  (seq_start),
    .seq_fetch  (seq_fetch),
    .seq_addr   (seq_addr),
    .trig_addr  (enable_q[TRIG_LSB +: SEQ_AW]),
    .fifo_count (fifo_count),
    .fifo_code  (enable_q[FIFO_LSB +: FIFO_TW]),
    .addr_hit   (addr_hit),
    .fifo_hit   (fifo_hit)
  );

  irq_settle_timer #(
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .standby  (standby),
    .wake_hit (wake_hit)
  );

  always_comb begin
    ev_vec             = '0;
    ev_vec[F_LIMIT]    = ev_limit;
    ev_vec[F_ADDR]     = addr_hit;
    ev_vec[F_FIFO]     = fifo_hit;
    ev_vec[F_SHORTCAL] = ev_short_cal;
    ev_vec[F_FULLCAL]  = ev_full_cal;
    ev_vec[F_PAUSE]    = ev_pause;
    ev_vec[F_WAKE]     = wake_hit;
  end

  irq_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_vec   (ev_vec),
    .clr      (stat_read),
    .en_mask  (enable_q[NFLAG-1:0]),
    .status_q (status_q),
    .irq      (irq)
  );
endmodule

// File: rtl/daq_irq_chk.sv
module daq_irq_chk
  import daq_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       bus_addr,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [15:0]      bus_wdata,
  input logic [NFLAG-1:0] ev_vec,
  input logic [NFLAG-1:0] status_q,
  input logic [15:0]      enable_q,
  input logic             irq
);
  // R3
  set_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_vec) |=> ((status_q & $past(ev_vec)) == $past(ev_vec)));

  // R4
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_addr == ADDR_STATUS) |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R4
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_STATUS && ev_vec == '0) |=> (status_q == '0));

  // R5
  read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_STATUS && (|ev_vec)) |=> (status_q == ($past(ev_vec) & FLAG_MASK)));

  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_q & enable_q[NFLAG-1:0] & FLAG_MASK)) |=> irq);

  // R6
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status_q & enable_q[NFLAG-1:0] & FLAG_MASK)) |=> !irq);

  // R2
  enable_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_ENABLE) |=> (enable_q == ($past(bus_wdata) & 16'hFFBF)));
endmodule

bind daq_irq_ctrl daq_irq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .ev_vec    (ev_vec),
  .status_q  (status_q),
  .enable_q  (enable_q),
  .irq       (irq)
);

// File: tb/tb_daq_irq_ctrl.sv
module tb_daq_irq_ctrl;
  localparam int CLK_P  = 10;
  localparam int SETTLE = 6;
  localparam logic [3:0] A_EN = 4'h9;
  localparam logic [3:0] A_ST = 4'hA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ev_limit = 1'b0, ev_pause = 1'b0, ev_short_cal = 1'b0, ev_full_cal = 1'b0;
  logic        seq_start = 1'b0, seq_fetch = 1'b0;
  logic [2:0]  seq_addr = '0;
  logic [5:0]  fifo_count = '0;
  logic        standby = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  daq_irq_ctrl #(.SETTLE_CYCLES(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_limit(ev_limit), .ev_pause(ev_pause),
    .ev_short_cal(ev_short_cal), .ev_full_cal(ev_full_cal), .seq_start(seq_start),
    .seq_fetch(seq_fetch), .seq_addr(seq_addr), .fifo_count(fifo_count),
    .standby(standby), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd_clr(output logic [15:0] d);
    bus_addr = A_ST; bus_rd = 1'b1;
    #1;
    d = bus_rdata;
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic pulse_src(input int s);
    case (s)
      0: ev_limit = 1'b1;
      1: ev_short_cal = 1'b1;
      2: ev_full_cal = 1'b1;
      default: ev_pause = 1'b1;
    endcase
    tick();
    ev_limit = 1'b0; ev_short_cal = 1'b0; ev_full_cal = 1'b0; ev_pause = 1'b0;
  endtask

  task automatic fetch(input logic [2:0] a);
    seq_addr = a; seq_fetch = 1'b1;
    tick();
    seq_fetch = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    bit armed;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 irq", irq, 0);
    peek(A_EN, d); chk("R1 enable", d, 0);
    peek(A_ST, d); chk("R1 status", d, 0);

    // R2 enable register write/read, bit 6 masked
    for (int k = 0; k < 17; k++) begin
      logic [15:0] v;
      v = (k == 16) ? 16'hFFFF : (16'h1 << k);
      wr(A_EN, v);
      peek(A_EN, d); chk("R2 enable readback", d, v & 16'hFFBF);
    end
    wr(A_ST, 16'hFFFF);
    peek(A_ST, d); chk("R2 status write ignored", d, 0);
    peek(4'h3, d); chk("R2 unmapped read", d, 0);
    wr(A_EN, 16'h0000);

    // R3 R4 R6 sweep over every enable mask and each pulse source
    for (int en = 0; en < 256; en++) begin
      wr(A_EN, 16'(en));
      rd_clr(d);
      for (int s = 0; s < 4; s++) begin
        int b;
        b = (s == 0) ? 0 : (s == 1) ? 3 : (s == 2) ? 4 : 5;
        pulse_src(s);
        peek(A_ST, d); chk("R3 flag set", d, 16'(1 << b));
        tick();
        chk("R6 irq gate", irq, (en >> b) & 1);
        rd_clr(d); chk("R4 read returns old", d, 16'(1 << b));
        peek(A_ST, d); chk("R4 cleared", d, 0);
        tick();
        chk("R6 irq drops", irq, 0);
      end
    end

    // R5 event concurrent with clearing read
    wr(A_EN, 16'h0000);
    pulse_src(3);
    bus_addr = A_ST; bus_rd = 1'b1; ev_limit = 1'b1;
    #1; d = bus_rdata; chk("R5 read old value", d, 16'h0020);
    tick();
    bus_rd = 1'b0; ev_limit = 1'b0;
    peek(A_ST, d); chk("R5 new event kept", d, 16'h0001);
    rd_clr(d);

    // R7 R8 instruction-address trigger sweep
    for (int t = 0; t < 8; t++) begin
      wr(A_EN, 16'(t << 8));
      rd_clr(d);
      seq_start = 1'b1; tick(); seq_start = 1'b0;
      armed = 1;
      for (int p = 0; p < 2; p++) begin
        for (int a = 0; a < 8; a++) begin
          bit exp;
          exp = (a == t) && !(armed && a == 0);
          if (a == 0) armed = 0;
          fetch(3'(a));
          peek(A_ST, d); chk("R7 R8 address trigger", d[1], exp);
          if (d != 0) rd_clr(d);
        end
      end
      seq_addr = 3'(t); tick();
      peek(A_ST, d); chk("R7 no strobe no flag", d[1], 0);
    end
    // R8 re-arm by start with trigger 0
    wr(A_EN, 16'h0000);
    fetch(3'd0); rd_clr(d);
    seq_start = 1'b1; tick(); seq_start = 1'b0;
    fetch(3'd0);
    peek(A_ST, d); chk("R8 start rearms", d[1], 0);
    fetch(3'd0);
    peek(A_ST, d); chk("R8 second fetch flags", d[1], 1);
    rd_clr(d);
    // R8 re-arm by reset
    rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
    fetch(3'd0);
    peek(A_ST, d); chk("R8 reset rearms", d[1], 0);
    fetch(3'd0);
    peek(A_ST, d); chk("R8 after reset second fetch", d[1], 1);
    rd_clr(d);

    // R9 FIFO threshold sweep
    for (int code = 0; code < 32; code++) begin
      int thr;
      thr = (code == 0) ? 32 : code;
      fifo_count = '0; tick();
      wr(A_EN, 16'(code << 11));
      rd_clr(d);
      for (int c = 0; c <= 32; c++) begin
        fifo_count = 6'(c); tick();
        peek(A_ST, d); chk("R9 fifo threshold", d[2], (c == thr) ? 1 : 0);
        if (d != 0) rd_clr(d);
      end
      tick();
      peek(A_ST, d); chk("R9 no retrigger while held", d[2], 0);
    end
    fifo_count = '0; tick();

    // R10 standby exit settling delay
    wr(A_EN, 16'h0080);
    standby = 1'b1; repeat (3) tick();
    rd_clr(d);
    standby = 1'b0;
    for (int j = 1; j <= SETTLE + 1; j++) begin
      tick();
      peek(A_ST, d); chk("R10 wake timing", d[7], (j == SETTLE + 1) ? 1 : 0);
    end
    tick();
    chk("R6 wake irq", irq, 1);
    rd_clr(d);
    // R10 cancellation by re-entering standby
    standby = 1'b1; repeat (3) tick();
    standby = 1'b0; repeat (2) tick();
    standby = 1'b1;
    for (int j = 0; j < SETTLE + 3; j++) begin
      tick();
      peek(A_ST, d); chk("R10 cancelled", d[7], 0);
    end
    standby = 1'b0;
    tick(); tick();
    chk("R6 irq idle", irq, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule